// File: doc/BRIEF.md
# Double-Buffered Audio DMA Controller

This block streams stereo audio out of memory. Software places up to two buffers in a small queue, each given as a byte address and a byte length. A free-running timer produces a sample tick at a rate chosen by a divider register. On each tick, while output is enabled and a buffer is queued, the block reads one 32-bit word from memory. It splits that word into a signed left sample (upper half) and a signed right sample (lower half) and presents the pair with a one-cycle valid.

When the active buffer runs out, the block raises its interrupt line, drops the buffer count and promotes the waiting buffer, if any, into the active slot. Software refills the queue from the interrupt handler, which keeps playback gapless. The fetch address uses a split counter. The low 13 bits step by 4 and wrap. A wrap leaves a carry that is folded into the upper 11 bits only when the next fetch is issued, and that carry survives a buffer switch.

Top module: `audio_dma_engine`

## Requirements
- R1: After reset the interrupt is low, no memory request or sample is produced, the length register reads 0, the divider is 0 and the exported bit-rate field is 0.
- R2: A write to offset 0x00 keeps byte-address bits 23:3 (bits 2:0 read as zero) and is dropped while two buffers are queued. A write to offset 0x04 keeps length bits 17:3. It is dropped when that result is zero or two buffers are already queued. Otherwise it fills the slot given by the buffer count and raises the count by one.
- R3: Offset 0x0C reads 0x01100000 when the queue is empty, 0x41100000 with one buffer, and 0xC1100001 with two buffers (bit 31 and bit 0 mean full, bit 30 means busy, bits 24 and 20 are constant ones).
- R4: With divider value D (offset 0x10, 14 bits), ticks occur every 2×(D+1) cycles. When memory answers within that period, consecutive fetches of a run are exactly 2×(D+1) cycles apart.
- R5: Each memory response yields, one cycle later, smp_valid for one cycle with smp_left equal to response bits 31:16 and smp_right equal to bits 15:0.
- R6: The address low 13 bits advance by 4 after each response and wrap. A wrap to zero adds one to bits 23:13 (modulo 2048) at the next fetch, even when that fetch belongs to the next buffer. mem_addr carries the byte address divided by 4.
- R7: Offset 0x04 reads the remaining length of the active buffer, which drops by 4 per response.
- R8: The response that empties the active buffer sets the interrupt and lowers the count. If a second buffer was waiting, its address and length become active.
- R9: No memory request is issued while the queue is empty.
- R10: At most one fetch is outstanding. A tick that lands while a fetch is outstanding is kept, so fetches are then spaced by the response latency plus one cycle.
- R11: Any write to offset 0x0C clears the interrupt, unless a buffer empties in the same cycle, in which case the interrupt stays set.
- R12: While control bit 0 (offset 0x08) is 0, no fetch is issued, even with buffers queued.
- R13: A write to offset 0x14 stores data bits 3:0, which appear on dac_bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_req | output | 1 | One-cycle fetch request |
| mem_addr | output | 22 | Word address of the fetch |
| mem_rvalid | input | 1 | Fetch response valid |
| mem_rdata | input | 32 | Fetch response data |
| smp_valid | output | 1 | Stereo sample valid |
| smp_left | output | 16 | Signed left sample |
| smp_right | output | 16 | Signed right sample |
| irq | output | 1 | Buffer-drained interrupt |
| dac_bits | output | BITS_W | Stored bit-rate field |

## Verification
The hardest state to reach is a buffer completion that falls in the same cycle as a write to the status offset. The bench reaches it by taking over the memory port. It waits for the final fetch request and then drives the response and the status write on the same edge. The delayed carry is reached by placing a buffer whose final word sits just below an 8 KiB boundary, followed by a buffer elsewhere. The second buffer's first fetch then lands one 8 KiB page above its programmed address. Tick holding is covered by sweeping divider values against memory latencies both shorter and longer than the tick period, and checking every request spacing.

// File: rtl/adma_pkg.sv
package adma_pkg;
    localparam int ADDR_W = 24;   // byte address width kept from writes
    localparam int LEN_W  = 18;   // byte length width kept from writes
    localparam int LO_W   = 13;   // wrapping low part of the address counter
    localparam int ALIGN  = 3;    // low bits forced to zero on address/length
    localparam int WORD_B = 4;    // bytes per fetched word
    localparam int SMP_W  = 16;   // bits per channel sample

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
    } slot_t;

    typedef struct packed {
        slot_t      s1;
        slot_t      s0;
        logic [1:0] cnt;
        logic       carry;
        logic       irq;
    } queue_st_t;
endpackage

// File: rtl/adma_timer.sv
module adma_timer #(
    parameter int RATE_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int CNT_W = RATE_W + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit = {rate, 1'b1};          // 2*(rate+1) - 1
        tick  = (cnt_q >= limit);
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4: a tick is always followed by at least one quiet cycle
    p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/adma_queue.sv
module adma_queue
    import adma_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_addr,
    input  logic                    wr_len,
    input  logic [ADDR_W-1:ALIGN]   wdata,
    input  logic                    irq_clr,
    input  logic                    issue,
    input  logic                    done,
    output logic [1:0]              cnt,
    output logic [ADDR_W-1:2]       fetch_word,
    output logic [LEN_W-1:0]        act_len,
    output logic                    irq
);
    localparam int HI_W = ADDR_W - LO_W;

    queue_st_t         q_d, q_q;
    logic [ADDR_W-1:0] fetch_addr;
    logic [LO_W-1:0]   lo_nxt;
    logic [ADDR_W-1:0] a_mask;
    logic [LEN_W-1:0]  l_mask;
    logic              drain;

    always_comb begin
        q_d        = q_q;
        fetch_addr = {q_q.s0.addr[ADDR_W-1:LO_W] + HI_W'(q_q.carry),
                      q_q.s0.addr[LO_W-1:0]};
        lo_nxt     = q_q.s0.addr[LO_W-1:0] + LO_W'(WORD_B);
        drain      = done && (q_q.s0.len == LEN_W'(WORD_B));
        a_mask     = {wdata, {ALIGN{1'b0}}};
        l_mask     = {wdata[LEN_W-1:ALIGN], {ALIGN{1'b0}}};

        if (issue) begin
            q_d.s0.addr = fetch_addr;
            q_d.carry   = 1'b0;
        end
        if (done) begin
            q_d.s0.addr[LO_W-1:0] = lo_nxt;
            q_d.carry             = (lo_nxt == '0);
            q_d.s0.len            = q_q.s0.len - LEN_W'(WORD_B);
        end
        if (irq_clr) q_d.irq = 1'b0;
        if (drain) begin
            q_d.irq = 1'b1;
            q_d.cnt = q_q.cnt - 2'd1;
            if (q_q.cnt == 2'd2) q_d.s0 = q_q.s1;
        end
        // register writes index the queue by the post-completion count
        if (wr_addr && q_d.cnt < 2'd2) begin
            if (q_d.cnt[0]) q_d.s1.addr = a_mask;
            else            q_d.s0.addr = a_mask;
        end
        if (wr_len && q_d.cnt < 2'd2 && l_mask != '0) begin
            if (q_d.cnt[0]) q_d.s1.len = l_mask;
            else            q_d.s0.len = l_mask;
            q_d.cnt = q_d.cnt + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign cnt        = q_q.cnt;
    assign fetch_word = fetch_addr[ADDR_W-1:2];
    assign act_len    = q_q.s0.len;
    assign irq        = q_q.irq;

    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= 2'd2);
    p_drain_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && act_len == LEN_W'(WORD_B)) |=> irq);
    p_promote_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && act_len == LEN_W'(WORD_B) && cnt == 2'd2 && !wr_len)
        |=> (cnt == 2'd1 && act_len == $past(q_q.s1.len)));
    p_len_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && act_len != LEN_W'(WORD_B)) |=> act_len == $past(act_len) - LEN_W'(WORD_B));
    p_irq_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !(done && act_len == LEN_W'(WORD_B))) |=> !irq);
endmodule

// File: rtl/audio_dma_engine.sv
module audio_dma_engine
    import adma_pkg::*;
#(
    parameter int RATE_W = 14,
    parameter int BITS_W = 4,
    parameter int REG_AW = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic                mem_req,
    output logic [ADDR_W-3:0]   mem_addr,
    input  logic                mem_rvalid,
    input  logic [31:0]         mem_rdata,
    output logic                smp_valid,
    output logic [SMP_W-1:0]    smp_left,
    output logic [SMP_W-1:0]    smp_right,
    output logic                irq,
    output logic [BITS_W-1:0]   dac_bits
);
    localparam logic [REG_AW-1:0] OFF_ADDR = REG_AW'(8'h00);
    localparam logic [REG_AW-1:0] OFF_LEN  = REG_AW'(8'h04);
    localparam logic [REG_AW-1:0] OFF_CTRL = REG_AW'(8'h08);
    localparam logic [REG_AW-1:0] OFF_STAT = REG_AW'(8'h0C);
    localparam logic [REG_AW-1:0] OFF_RATE = REG_AW'(8'h10);
    localparam logic [REG_AW-1:0] OFF_BITS = REG_AW'(8'h14);

    typedef struct packed {
        logic              en;
        logic [RATE_W-1:0] rate;
        logic [BITS_W-1:0] bits;
        logic              busy;
        logic              pend;
        logic              sv;
        logic [SMP_W-1:0]  sl;
        logic [SMP_W-1:0]  sr;
    } ctl_st_t;

    ctl_st_t           c_d, c_q;
    logic              tick, issue, done;
    logic [1:0]        cnt;
    logic [LEN_W-1:0]  act_len;
    logic [ADDR_W-1:2] fetch_word;
    logic              unused_wbits;

    assign unused_wbits = ^reg_wdata[31:ADDR_W];

    adma_timer #(.RATE_W(RATE_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .rate  (c_q.rate),
        .tick  (tick)
    );

    adma_queue u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_addr    (reg_wr && reg_addr == OFF_ADDR),
        .wr_len     (reg_wr && reg_addr == OFF_LEN),
        .wdata      (reg_wdata[ADDR_W-1:ALIGN]),
        .irq_clr    (reg_wr && reg_addr == OFF_STAT),
        .issue      (issue),
        .done       (done),
        .cnt        (cnt),
        .fetch_word (fetch_word),
        .act_len    (act_len),
        .irq        (irq)
    );

    always_comb begin
        c_d    = c_q;
        issue  = c_q.en && cnt != 2'd0 && !c_q.busy && (tick || c_q.pend);
        done   = c_q.busy && mem_rvalid;

        c_d.pend = !issue && cnt != 2'd0 && (c_q.pend || (tick && c_q.busy));
        c_d.busy = issue || (c_q.busy && !mem_rvalid);
        c_d.sv   = done;
        if (done) begin
            c_d.sl = mem_rdata[31:16];
            c_d.sr = mem_rdata[15:0];
        end
        if (reg_wr) begin
            case (reg_addr)
                OFF_CTRL: c_d.en   = reg_wdata[0];
                OFF_RATE: c_d.rate = reg_wdata[RATE_W-1:0];
                OFF_BITS: c_d.bits = reg_wdata[BITS_W-1:0];
                default:  ;
            endcase
        end

        case (reg_addr)
            OFF_LEN:  reg_rdata = 32'(act_len);
            OFF_STAT: reg_rdata = {cnt == 2'd2, cnt != 2'd0, 5'b0, 1'b1,
                                   3'b0, 1'b1, 19'b0, cnt == 2'd2};
            default:  reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign mem_req   = issue;
    assign mem_addr  = fetch_word;
    assign smp_valid = c_q.sv;
    assign smp_left  = c_q.sl;
    assign smp_right = c_q.sr;
    assign dac_bits  = c_q.bits;

    p_single_outstanding_r10: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.busy |-> !mem_req);
    p_no_fetch_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == 2'd0) |-> !mem_req);
    p_enable_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !c_q.en |-> !mem_req);
    p_sample_after_resp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> $past(mem_rvalid));
    p_req_clears_pend_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> c_q.busy);
endmodule

// File: tb/audio_dma_engine_tb.sv
module audio_dma_engine_tb;
    localparam int CLK_NS = 10;

    logic        clk = 0, rst_n = 0;
    logic        reg_wr = 0;
    logic [4:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic        mem_req, mem_rvalid = 0;
    logic [21:0] mem_addr;
    logic [31:0] mem_rdata = 0;
    logic        smp_valid, irq;
    logic [15:0] smp_left, smp_right;
    logic [3:0]  dac_bits;

    always #(CLK_NS/2) clk = ~clk;

    audio_dma_engine u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .smp_valid(smp_valid), .smp_left(smp_left), .smp_right(smp_right),
        .irq(irq), .dac_bits(dac_bits)
    );

    int n_cmp = 0, n_bad = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // bench model of the queue, built from the requirements
    int unsigned m_addr[2], m_len[2];
    int m_cnt = 0, m_carry = 0, m_en = 0;
    int lat = 1, rate = 0;
    int auto_resp = 1, fresh = 1, last_req = 0, samples = 0, n_req = 0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_all();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    function automatic logic [31:0] pat(logic [21:0] wa);
        return {wa[15:0] ^ 16'h8C3B, 16'hF00F ^ {wa[7:0], wa[15:8]}};
    endfunction

    task automatic wr(logic [4:0] a, logic [31:0] d);
        int unsigned am, lm;
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        am = d & 32'h00FF_FFF8;
        lm = d & 32'h0003_FFF8;
        if (a == 5'h00 && m_cnt < 2) m_addr[m_cnt] = am;
        if (a == 5'h04 && m_cnt < 2 && lm != 0) begin m_len[m_cnt] = lm; m_cnt++; end
        if (a == 5'h08) m_en = d[0];
        if (a == 5'h10) rate = d & 32'h3FFF;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    // memory responder and per-fetch checks
    initial begin
        forever begin
            if (!(auto_resp && mem_req)) @(negedge clk);
            else begin
                int unsigned hi, exp_a, lo, per, want;
                logic [31:0] d;
                logic drained;
                n_req++;
                if (m_cnt == 0 || m_en == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL R9/R12 unexpected request actual=1 expected=0");
                end
                hi    = (((m_addr[0] >> 13) + m_carry) & 32'h7FF);
                exp_a = (hi << 13) | (m_addr[0] & 32'h1FFF);
                check("R6 fetch address", 32'(mem_addr), exp_a >> 2);
                m_addr[0] = exp_a; m_carry = 0;
                per  = 2 * (rate + 1);
                want = (per > lat + 1) ? per : lat + 1;
                if (!fresh) check("R4/R10 request spacing", cyc - last_req, want);
                fresh = 0; last_req = cyc;
                repeat (lat) @(negedge clk);
                d = pat(mem_addr);
                mem_rvalid = 1; mem_rdata = d;
                lo = (m_addr[0] + 4) & 32'h1FFF;
                m_addr[0] = (m_addr[0] & ~32'h1FFF) | lo;
                m_carry = (lo == 0);
                m_len[0] -= 4;
                drained = (m_len[0] == 0);
                if (drained) begin
                    m_cnt--;
                    if (m_cnt == 1) begin m_addr[0] = m_addr[1]; m_len[0] = m_len[1]; end
                end
                @(negedge clk);
                mem_rvalid = 0;
                check("R5 sample valid", 32'(smp_valid), 1);
                check("R5 left sample", 32'(smp_left), 32'(d[31:16]));
                check("R5 right sample", 32'(smp_right), 32'(d[15:0]));
                if (drained) check("R8 irq on drain", 32'(irq), 1);
                samples++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_all();
    end

    task automatic drain_and_clear();
        logic [31:0] v;
        wait (m_cnt == 0);
        repeat (lat + 4) @(negedge clk);
        rd(5'h0C, v); check("R8 status after drain", v, 32'h0110_0000);
        check("R8 irq held", 32'(irq), 1);
        wr(5'h0C, 0);
        check("R11 irq cleared", 32'(irq), 0);
        wr(5'h08, 0);
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        check("R1 irq after reset", 32'(irq), 0);
        check("R1 no request", 32'(mem_req), 0);
        check("R1 no sample", 32'(smp_valid), 0);
        check("R1 bit-rate", 32'(dac_bits), 0);
        rd(5'h04, v); check("R1 length reads 0", v, 0);
        rd(5'h0C, v); check("R3 empty status", v, 32'h0110_0000);
        rst_n = 1;
        @(negedge clk);

        wr(5'h04, 32'h000C_0007);                 // masks to zero: ignored
        rd(5'h0C, v); check("R2 zero length ignored", v, 32'h0110_0000);
        wr(5'h00, 32'hFF00_1FFF);                 // -> 0x001FF8
        wr(5'h04, 32'hFFF0_0013);                 // -> 0x10
        rd(5'h04, v); check("R2/R7 masked length", v, 32'h10);
        rd(5'h0C, v); check("R3 one queued", v, 32'h4110_0000);
        wr(5'h00, 32'h00FF_FFF8);
        wr(5'h04, 32'h10);
        rd(5'h0C, v); check("R3 two queued", v, 32'hC110_0001);
        wr(5'h00, 32'h0012_3450);                 // dropped, queue full
        wr(5'h04, 32'h8);                         // dropped, queue full
        rd(5'h0C, v); check("R2 full write ignored", v, 32'hC110_0001);
        rd(5'h04, v); check("R2 active length kept", v, 32'h10);
        wr(5'h14, 32'hAB);
        check("R13 bit-rate field", 32'(dac_bits), 32'hB);
        wr(5'h10, 1);
        repeat (40) @(negedge clk);
        check("R12 no fetch while disabled", n_req, 0);
        fresh = 1;
        wr(5'h08, 1);                             // low-wrap and 11-bit wrap run
        drain_and_clear();
        check("R8 eight samples over two buffers", samples, 8);

        // R6: carry left by a buffer ending at a page wrap moves the next one
        wr(5'h00, 32'h1FF8); wr(5'h04, 8);
        wr(5'h00, 32'h4000); wr(5'h04, 8);
        fresh = 1; wr(5'h08, 1);
        drain_and_clear();

        // R7: remaining length during a slow run
        wr(5'h10, 30);
        wr(5'h00, 32'h300); wr(5'h04, 32'h20);
        samples = 0; fresh = 1; wr(5'h08, 1);
        wait (samples == 3);
        rd(5'h04, v); check("R7 remaining length", v, 32'h14);
        drain_and_clear();

        // R4/R10 sweep: divider values against memory latencies
        for (int r = 0; r < 4; r++) begin
            for (int l = 0; l < 3; l++) begin
                int unsigned base;
                lat  = (l == 0) ? 1 : (l == 1) ? 2 : 5;
                base = 32'h1FE8 + r * 32'h40 + l * 32'h2000;
                wr(5'h10, (r == 3) ? 6 : r);
                wr(5'h00, base);        wr(5'h04, 32'h18);
                wr(5'h00, base + 32'h800); wr(5'h04, 32'h18);
                fresh = 1; wr(5'h08, 1);
                drain_and_clear();
            end
        end

        // R11: completion and status write in the same cycle
        auto_resp = 0; lat = 1;
        wr(5'h10, 0);
        wr(5'h00, 32'h40); wr(5'h04, 8);
        wr(5'h08, 1);
        while (!mem_req) @(negedge clk);
        @(negedge clk); mem_rvalid = 1; mem_rdata = 32'h1234_5678;
        @(negedge clk); mem_rvalid = 0;
        while (!mem_req) @(negedge clk);
        @(negedge clk);
        mem_rvalid = 1; reg_wr = 1; reg_addr = 5'h0C; reg_wdata = 0;
        @(negedge clk);
        mem_rvalid = 0; reg_wr = 0;
        check("R11 completion wins over clear", 32'(irq), 1);
        @(negedge clk); reg_wr = 1; reg_addr = 5'h0C;
        @(negedge clk); reg_wr = 0;
        check("R11 later clear", 32'(irq), 0);
        rd(5'h0C, v); check("R9 queue empty after manual run", v, 32'h0110_0000);
        finish_all();
    end
endmodule